// File: doc/BRIEF.md
# Trailing-Ones Mask and Incrementer

This block takes a 64-bit operand and isolates the run of ones that begins at bit 0: every bit from the lowest clear bit upward is forced to zero. From that mask it derives two further results. The first is a one-hot word that marks the position of the lowest clear bit, which is where a carry into the operand stops. The second is the operand plus one.

The mask is built from six shift-and-AND stages with shift distances of 1, 2, 4, 8, 16 and 32. Each stage fills the vacated low bits with ones, so the logic depth grows with the logarithm of the width and not with the width itself. The operand is processed as a low and a high 32-bit half. At every stage, bits shifted out of the top of the low half enter the bottom of the high half. The last stage, with a shift of 32, lets a run of ones that fills the whole low half reach into the high half.

All results are captured together on the clock edge that samples a valid strobe. A matching valid pulse follows for one cycle. Callers use it as a fast incrementer that also reports where the carry stops and whether it leaves the word.

Top module: `tom_incr`

## Requirements
- R1: The mask output keeps exactly the contiguous ones starting at bit 0 and is zero at and above the lowest clear bit of the operand (operand 0xA7 gives mask 0x07; operand 0 gives mask 0).
- R2: The mask is correct when the lowest clear bit lies at or above bit 32 (operand 0x1_FFFF_FFFF gives mask 0x1_FFFF_FFFF; operand 0x7FFF_FFFF_FFFF_FFFF gives itself).
- R3: The carry-position output has exactly one bit set, at the index of the operand's lowest clear bit (operand 0xA7 gives 0x08; operand 0 gives 0x1), and is zero when the operand has no clear bit.
- R4: The increment output equals the operand plus one, modulo 2^64.
- R5: For an all-ones operand the mask is all ones, the carry position is zero, the increment is zero and the overflow output is 1. For any other operand the overflow output is 0.
- R6: Results update on the rising edge that samples valid_in high, and valid_out is high for exactly the cycle that follows that edge.
- R7: On edges where valid_in is low, the mask, carry-position, increment and overflow outputs keep their values.
- R8: A synchronous active-high reset clears valid_out and all result outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operand strobe |
| operand_in | input | 64 | Operand to scan and increment |
| valid_out | output | 1 | One-cycle pulse marking fresh results |
| ones_mask_out | output | 64 | Trailing-ones mask |
| carry_pos_out | output | 64 | One-hot position of the lowest clear bit |
| incr_out | output | 64 | Operand plus one |
| overflow_out | output | 1 | Set when the increment carries out of bit 63 |

## Verification
Every result passes through exactly one register, so mask, carry position, increment, overflow and valid_out are all due in the cycle right after the edge that samples the strobe. The bench drives the operand and strobe on a falling edge, drops the strobe on the next falling edge and checks all outputs at that point. One cycle later it checks that valid_out has fallen and the results have held. Expected values come from a bit-by-bit scan of the operand in the bench, not from the stage structure.

// File: rtl/tom_pkg.sv
package tom_pkg;

    localparam int WORD_W     = 64;
    localparam int HALF_W     = WORD_W / 2;
    localparam int NUM_STAGES = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        word_t mask;
        word_t carry_pos;
        word_t incr;
        logic  ovf;
    } tom_result_t;

    // Ones in the lowest n bits of a half word.
    function automatic half_t low_ones(input int n);
        half_t r;
        for (int i = 0; i < HALF_W; i++) begin
            r[i] = (i < n);
        end
        return r;
    endfunction

    function automatic word_t join_halves(input half_t hi, input half_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/tom_fill_stage.sv
module tom_fill_stage
    import tom_pkg::*;
#(
    parameter int SHIFT = 1
) (
    input  half_t lo_i,
    input  half_t hi_i,
    output half_t lo_o,
    output half_t hi_o
);

    generate
        if (SHIFT < HALF_W) begin : g_split
            localparam half_t FILL = low_ones(SHIFT);
            half_t lo_sh;
            half_t hi_sh;
            always_comb begin
                lo_sh = (lo_i << SHIFT) | FILL;
                hi_sh = (hi_i << SHIFT) | (lo_i >> (HALF_W - SHIFT));
                lo_o  = lo_i & lo_sh;
                hi_o  = hi_i & hi_sh;
            end
        end else begin : g_cross
            // Whole low half moves into the high half; ones fill the low half.
            always_comb begin
                lo_o = lo_i;
                hi_o = hi_i & lo_i;
            end
        end
    endgenerate

    // R1: a stage may only clear bits, never set them.
    always_comb begin
        a_r1_stage_clears_only: assert (((lo_o & ~lo_i) == '0) && ((hi_o & ~hi_i) == '0))
            else $error("stage %0d set a bit", SHIFT);
    end

endmodule

// File: rtl/tom_mask_chain.sv
module tom_mask_chain
    import tom_pkg::*;
(
    input  word_t operand,
    output word_t mask
);

    half_t lo_s [0:NUM_STAGES];
    half_t hi_s [0:NUM_STAGES];

    assign lo_s[0] = operand[HALF_W-1:0];
    assign hi_s[0] = operand[WORD_W-1:HALF_W];

    generate
        for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
            tom_fill_stage #(
                .SHIFT (1 << g)
            ) u_stage (
                .lo_i (lo_s[g]),
                .hi_i (hi_s[g]),
                .lo_o (lo_s[g+1]),
                .hi_o (hi_s[g+1])
            );
        end
    endgenerate

    assign mask = join_halves(hi_s[NUM_STAGES], lo_s[NUM_STAGES]);

    // R1: the finished mask is a contiguous run of ones from bit 0.
    always_comb begin
        a_r1_mask_contiguous: assert (((mask + word_t'(1)) & mask) == '0)
            else $error("mask not contiguous");
    end

endmodule

// File: rtl/tom_derive.sv
module tom_derive
    import tom_pkg::*;
(
    input  word_t       operand,
    input  word_t       mask,
    output tom_result_t result
);

    word_t flip;

    always_comb begin
        flip             = (mask << 1) | word_t'(1);
        result.mask      = mask;
        result.carry_pos = flip & ~mask;
        result.incr      = operand ^ flip;
        result.ovf       = mask[WORD_W-1];
    end

    // R3: the carry position always lands on a clear operand bit.
    always_comb begin
        a_r3_pos_on_zero: assert ((result.carry_pos & operand) == '0)
            else $error("carry position on a set bit");
    end

endmodule

// File: rtl/tom_incr.sv
module tom_incr
    import tom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [WORD_W-1:0] operand_in,
    output logic              valid_out,
    output logic [WORD_W-1:0] ones_mask_out,
    output logic [WORD_W-1:0] carry_pos_out,
    output logic [WORD_W-1:0] incr_out,
    output logic              overflow_out
);

    word_t       mask_c;
    tom_result_t res_c;
    tom_result_t res_q;
    logic        vld_q;

    tom_mask_chain u_chain (
        .operand (operand_in),
        .mask    (mask_c)
    );

    tom_derive u_derive (
        .operand (operand_in),
        .mask    (mask_c),
        .result  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= valid_in;
            if (valid_in) begin
                res_q <= res_c;
            end
        end
    end

    assign valid_out     = vld_q;
    assign ones_mask_out = res_q.mask;
    assign carry_pos_out = res_q.carry_pos;
    assign incr_out      = res_q.incr;
    assign overflow_out  = res_q.ovf;

    // Armed one cycle after reset so $past never reaches pre-reset values.
    logic chk_armed;
    always_ff @(posedge clk) begin
        if (rst) chk_armed <= 1'b0;
        else     chk_armed <= 1'b1;
    end

    a_r4_incr_matches: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && valid_out) |-> (incr_out == $past(operand_in) + word_t'(1)))
        else $error("increment mismatch");

    a_r3_pos_onehot: assert property (@(posedge clk) disable iff (rst)
        valid_out |-> $onehot0(carry_pos_out))
        else $error("carry position not one-hot");

    a_r5_ovf_wraps: assert property (@(posedge clk) disable iff (rst)
        (valid_out && overflow_out) |-> (incr_out == '0 && carry_pos_out == '0))
        else $error("overflow without wrap");

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
        chk_armed |-> (valid_out == $past(valid_in)))
        else $error("valid_out does not follow valid_in");

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (chk_armed && !$past(valid_in)) |-> ($stable(ones_mask_out) && $stable(incr_out)))
        else $error("results changed without strobe");

endmodule

// File: tb/tom_incr_tb.sv
module tom_incr_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic [63:0] operand_in;
    logic        valid_out;
    logic [63:0] ones_mask_out;
    logic [63:0] carry_pos_out;
    logic [63:0] incr_out;
    logic        overflow_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tom_incr u_dut (
        .clk           (clk),
        .rst           (rst),
        .valid_in      (valid_in),
        .operand_in    (operand_in),
        .valid_out     (valid_out),
        .ones_mask_out (ones_mask_out),
        .carry_pos_out (carry_pos_out),
        .incr_out      (incr_out),
        .overflow_out  (overflow_out)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference built from a plain bit scan.
    task automatic expect_for(input logic [63:0] x, output logic [63:0] m,
                              output logic [63:0] c, output logic [63:0] inc,
                              output logic o);
        bit run = 1'b1;
        m = '0;
        c = '0;
        for (int i = 0; i < 64; i++) begin
            if (run && x[i]) m[i] = 1'b1;
            else if (run) begin
                c[i] = 1'b1;
                run  = 1'b0;
            end
        end
        inc = x + 64'd1;
        o   = (x == '1);
    endtask

    task automatic apply_and_check(input logic [63:0] x, input string req);
        logic [63:0] m, c, inc;
        logic o;
        expect_for(x, m, c, inc, o);
        @(negedge clk);
        operand_in = x;
        valid_in   = 1'b1;
        @(negedge clk);
        valid_in   = 1'b0;
        operand_in = ~x;
        check("R6", "valid_out pulse", {63'd0, valid_out}, 64'd1);
        check(req,  "mask",       ones_mask_out, m);
        check("R3", "carry pos",  carry_pos_out, c);
        check("R4", "increment",  incr_out,      inc);
        check("R5", "overflow",   {63'd0, overflow_out}, {63'd0, o});
        @(negedge clk);
        check("R6", "valid_out drop", {63'd0, valid_out}, 64'd0);
        check("R7", "mask hold",      ones_mask_out, m);
        check("R7", "incr hold",      incr_out,      inc);
    endtask

    task automatic test_reset();
        rst        = 1'b1;
        valid_in   = 1'b1;
        operand_in = 64'h1234;
        repeat (2) @(negedge clk);
        check("R8", "reset valid", {63'd0, valid_out}, 64'd0);
        check("R8", "reset mask",  ones_mask_out, 64'd0);
        check("R8", "reset pos",   carry_pos_out, 64'd0);
        check("R8", "reset incr",  incr_out,      64'd0);
        check("R8", "reset ovf",   {63'd0, overflow_out}, 64'd0);
        valid_in = 1'b0;
        rst      = 1'b0;
    endtask

    task automatic test_low_runs();
        apply_and_check(64'h0000_0000_0000_00A7, "R1");
        check("R3", "0xA7 pos literal", carry_pos_out, 64'h8);
        apply_and_check(64'h0, "R1");
        check("R3", "zero pos literal", carry_pos_out, 64'h1);
        apply_and_check(64'h10FF_FFFF_FFFF_3333, "R1");
        apply_and_check(64'hDEAD_BEEF_0000_FFFE, "R1");
    endtask

    task automatic test_cross_half();
        apply_and_check(64'h0000_0000_FFFF_FFFF, "R2");
        apply_and_check(64'h0000_0001_FFFF_FFFF, "R2");
        check("R2", "bit33 mask literal", ones_mask_out, 64'h1_FFFF_FFFF);
        apply_and_check(64'h7FFF_FFFF_FFFF_FFFF, "R2");
        check("R2", "bit63 mask literal", ones_mask_out, 64'h7FFF_FFFF_FFFF_FFFF);
        apply_and_check(64'hA5FF_FFFF_FFFF_FFFF, "R2");
    endtask

    task automatic test_all_ones();
        apply_and_check(64'hFFFF_FFFF_FFFF_FFFF, "R5");
        check("R5", "wrap incr", incr_out, 64'd0);
        check("R5", "ovf set", {63'd0, overflow_out}, 64'd1);
    endtask

    task automatic test_idle_hold();
        logic [63:0] m0;
        m0 = ones_mask_out;
        @(negedge clk);
        operand_in = 64'h0F;
        valid_in   = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", "idle operand ignored", ones_mask_out, m0);
        check("R7", "idle valid low", {63'd0, valid_out}, 64'd0);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        operand_in = 64'h3;
        valid_in   = 1'b1;
        @(negedge clk);
        check("R6", "b2b first mask", ones_mask_out, 64'h3);
        operand_in = 64'h3F;
        @(negedge clk);
        valid_in = 1'b0;
        check("R6", "b2b second mask", ones_mask_out, 64'h3F);
        check("R6", "b2b valid still high", {63'd0, valid_out}, 64'd1);
        @(negedge clk);
        check("R6", "b2b valid drop", {63'd0, valid_out}, 64'd0);
    endtask

    initial begin
        test_reset();
        test_low_runs();
        test_cross_half();
        test_all_ones();
        test_idle_hold();
        test_back_to_back();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule